// File: doc/BRIEF.md
# Transmit Ring Space Allocator

This block hands out space in the transmit part of a shared packet memory that is used as a circular buffer. The host offers one frame at a time by pulsing a request strobe with the payload length. The block answers one cycle later. The answer says whether the frame is accepted and, for an accepted frame, the byte address where its header starts and the address where the following frame will start. An accepted frame moves the tail pointer. The transmitter reports finished frames one at a time, and each report moves the head pointer to the follow-on address that the block saved when it placed that frame.

The region bounds are fixed at build time from the memory size. The lowest three quarters of the memory belong to the receive path. The transmit region starts where the receive part ends and stops two bytes short of the end of memory. A frame header must stay contiguous. For that reason the space test sets aside one extra header length. When the tail sits so close to the region end that a header would not fit there, the frame is moved to the region base instead of being wrapped.

Top module: `tx_ring_alloc`

## Requirements
- R1: After a synchronous reset `ring_head` and `ring_tail` both equal the transmit base `MEM_BYTES*3/4` (24576 by default), and `rsp_valid` is low. The transmit top address is `MEM_BYTES-2` (32766). `ring_tail` always stays between these two addresses.
- R2: The space a frame needs is its payload length plus `HDR_BYTES` (8). An odd payload length is first rounded up to the next even value.
- R3: Free space is computed as follows. If tail minus head is zero or more, free space is the region size (8192) minus that difference. Otherwise it is the negated difference. A request is accepted only if free space is at least the needed space plus one more `HDR_BYTES`.
- R4: A rejected request answers with `rsp_accept` = 0 and leaves `ring_head` and `ring_tail` unchanged.
- R5: If tail plus the needed space does not exceed the top address, the start is the tail and the next address is the tail plus the needed space.
- R6: If tail plus the needed space exceeds the top address, and more than `HDR_BYTES` remain from the tail to the top address plus two, the start is the tail. The next address is the base plus the overflow past the top address, minus two.
- R7: If tail plus the needed space exceeds the top address, and at most `HDR_BYTES` remain from the tail to the top address plus two, the start is the base and the next address is the base plus the needed space.
- R8: When the ring is empty (head equals tail), an accepted frame also sets `ring_head` to that frame's start address.
- R9: Each `cmpl_valid` pulse retires the oldest outstanding frame and sets `ring_head` to that frame's next address. A pulse with no frame outstanding has no effect.
- R10: If a completion retires the last outstanding frame in the same cycle that a request is accepted, `ring_head` takes the new frame's start address.
- R11: `rsp_valid` is high for exactly the one cycle after a request strobe and low otherwise. On an accepted frame, `ring_tail` equals `rsp_next` in that same cycle.
- R12: At most `QDEPTH` (16) frames may be outstanding. A request made while `QDEPTH` frames are outstanding is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe for one frame |
| req_len | input | LEN_W | Payload length in bytes |
| cmpl_valid | input | 1 | Oldest outstanding frame finished transmitting |
| rsp_valid | output | 1 | Answer to the previous cycle's request |
| rsp_accept | output | 1 | Frame accepted |
| rsp_start | output | AW | Byte address of the frame header |
| rsp_next | output | AW | Byte address where the next frame begins |
| ring_head | output | AW | Oldest outstanding frame start |
| ring_tail | output | AW | Next free byte address |

## Verification
A request and a completion can land in the same cycle. The hard case is a completion that empties the ring while the new frame is being moved to the region base. In that case the head must jump to the base, not to the retired frame's next address. The bench sets this up by leaving one frame outstanding with the tail eight bytes below the region end. It then pulses both strobes together and checks the start, the next address, the head and the tail, followed by the state after one more completion. The bench also pulses both strobes together in an ordinary cycle, where the head must follow the stored next address and the tail must follow the new frame.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;

  typedef enum logic [1:0] {
    PLACE_LINEAR = 2'd0,
    PLACE_WRAP   = 2'd1,
    PLACE_SKIP   = 2'd2
  } place_e;

  function automatic int rx_share(input int mem_bytes);
    return (mem_bytes * 3) / 4;
  endfunction

endpackage

// File: rtl/tx_ring_fit.sv
module tx_ring_fit
  import tx_ring_pkg::*;
#(
  parameter int AW        = 15,
  parameter int LW        = 13,
  parameter int HDR_BYTES = 8,
  parameter int LO_ADDR   = 24576,
  parameter int HI_ADDR   = 32766,
  parameter int TX_BYTES  = 8192
) (
  input  logic [AW-1:0] head,
  input  logic [AW-1:0] tail,
  input  logic [LW-1:0] len,
  output logic          fits,
  output logic [AW-1:0] dest,
  output logic [AW-1:0] next,
  output place_e        place
);
  localparam int CW = ((AW > LW) ? AW : LW) + 3;
  localparam logic signed [CW-1:0] LO_S   = $signed(CW'(LO_ADDR));
  localparam logic signed [CW-1:0] HI_S   = $signed(CW'(HI_ADDR));
  localparam logic signed [CW-1:0] END_S  = $signed(CW'(HI_ADDR + 2));
  localparam logic signed [CW-1:0] HDR_S  = $signed(CW'(HDR_BYTES));
  localparam logic signed [CW-1:0] SIZE_S = $signed(CW'(TX_BYTES));

  logic [CW-1:0]        rsv_u;
  logic signed [CW-1:0] rsv, h_s, t_s, diff, free_b, end_pt, room;

  always_comb begin
    rsv_u  = CW'(len) + CW'(len[0]) + CW'(HDR_BYTES);
    rsv    = $signed(rsv_u);
    h_s    = $signed(CW'(head));
    t_s    = $signed(CW'(tail));
    diff   = t_s - h_s;
    free_b = (diff >= 0) ? (SIZE_S - diff) : -diff;
    fits   = (free_b >= (rsv + HDR_S));
    end_pt = t_s + rsv;
    room   = END_S - t_s;
    if (end_pt <= HI_S) begin
      place = PLACE_LINEAR;
      dest  = tail;
      next  = AW'(end_pt);
    end else if (room <= HDR_S) begin
      place = PLACE_SKIP;
      dest  = AW'(LO_S);
      next  = AW'(LO_S + rsv);
    end else begin
      place = PLACE_WRAP;
      dest  = tail;
      next  = AW'(LO_S + end_pt - END_S);
    end
  end

endmodule

// File: rtl/tx_ring_nextq.sv
module tx_ring_nextq #(
  parameter int AW     = 15,
  parameter int QDEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          pop,
  output logic [AW-1:0] front_addr,
  output logic          empty,
  output logic          full,
  output logic          last
);
  localparam int QW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CNTW = QW + 1;

  logic [AW-1:0]   store [QDEPTH];
  logic [QW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] count;

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == QW'(QDEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == QW'(QDEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign front_addr = store[rd_ptr];
  assign empty      = (count == '0);
  assign full       = (count == CNTW'(QDEPTH));
  assign last       = (count == CNTW'(1));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) push |-> (!full || pop)); // R12
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> !empty); // R9

endmodule

// File: rtl/tx_ring_alloc.sv
module tx_ring_alloc
  import tx_ring_pkg::*;
#(
  parameter int MEM_BYTES = 32768,
  parameter int HDR_BYTES = 8,
  parameter int LEN_W     = 13,
  parameter int QDEPTH    = 16,
  localparam int AW       = $clog2(MEM_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  input  logic             cmpl_valid,
  output logic             rsp_valid,
  output logic             rsp_accept,
  output logic [AW-1:0]    rsp_start,
  output logic [AW-1:0]    rsp_next,
  output logic [AW-1:0]    ring_head,
  output logic [AW-1:0]    ring_tail
);
  localparam int RX_BYTES = rx_share(MEM_BYTES);
  localparam int TX_BYTES = MEM_BYTES - RX_BYTES;
  localparam int LO_ADDR  = RX_BYTES;
  localparam int HI_ADDR  = MEM_BYTES - 2;

  logic          fit_ok, q_empty, q_full, q_last;
  logic          accept, retire, ring_empty;
  logic [AW-1:0] fit_dest, fit_next, q_front;
  logic [AW-1:0] head_q, tail_q;
  place_e        fit_place;

  tx_ring_fit #(
    .AW(AW), .LW(LEN_W), .HDR_BYTES(HDR_BYTES),
    .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR), .TX_BYTES(TX_BYTES)
  ) u_fit (
    .head(head_q), .tail(tail_q), .len(req_len),
    .fits(fit_ok), .dest(fit_dest), .next(fit_next), .place(fit_place)
  );

  assign ring_empty = (head_q == tail_q);
  assign accept     = req_valid && fit_ok && !q_full;
  assign retire     = cmpl_valid && !q_empty;

  tx_ring_nextq #(.AW(AW), .QDEPTH(QDEPTH)) u_nextq (
    .clk(clk), .rst(rst),
    .push(accept), .push_addr(fit_next),
    .pop(retire), .front_addr(q_front),
    .empty(q_empty), .full(q_full), .last(q_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q     <= AW'(LO_ADDR);
      tail_q     <= AW'(LO_ADDR);
      rsp_valid  <= 1'b0;
      rsp_accept <= 1'b0;
      rsp_start  <= '0;
      rsp_next   <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_accept <= accept;
      if (req_valid) begin
        rsp_start <= fit_dest;
        rsp_next  <= fit_next;
      end
      if (accept) tail_q <= fit_next;
      if (accept && ring_empty)
        head_q <= fit_dest;
      else if (retire && q_last && accept)
        head_q <= fit_dest;
      else if (retire)
        head_q <= q_front;
    end
  end

  assign ring_head = head_q;
  assign ring_tail = tail_q;

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst) req_valid |=> rsp_valid); // R11
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (rst) !req_valid |=> !rsp_valid); // R11
  AST_TAIL_FOLLOWS: assert property (@(posedge clk) disable iff (rst) (rsp_valid && rsp_accept) |-> (ring_tail == rsp_next)); // R11
  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (rst) (req_valid && !accept) |=> $stable(ring_tail)); // R4
  AST_PTR_WINDOW: assert property (@(posedge clk) disable iff (rst) (ring_tail >= AW'(LO_ADDR)) && (ring_tail <= AW'(HI_ADDR))); // R1
  AST_SKIP_BASE: assert property (@(posedge clk) disable iff (rst) (accept && fit_place == PLACE_SKIP) |=> (rsp_start == AW'(LO_ADDR))); // R7
  AST_EMPTY_HEAD: assert property (@(posedge clk) disable iff (rst) (accept && ring_empty) |=> (ring_head == rsp_start)); // R8

endmodule

// File: tb/tx_ring_alloc_bench.sv
`timescale 1ns/100ps
module tx_ring_alloc_bench;
  localparam int AW = 15;
  localparam int LW = 13;

  typedef struct packed {
    logic          rq;
    logic          cp;
    logic [LW-1:0] len;
    logic          acc;
    logic [AW-1:0] st;
    logic [AW-1:0] nx;
    logic [AW-1:0] hd;
    logic [AW-1:0] tl;
    logic [3:0]    rid;
  } vec_t;

  localparam int NV = 27;
  // R2/R3/R5 linear, R9 retire, R6 wrap, R7 skip, R8 empty head, R4 reject, R10 overlap
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 13'd100,  1'b1, 15'd24576, 15'd24684, 15'd24576, 15'd24684, 4'd5},
    '{1'b1, 1'b0, 13'd51,   1'b1, 15'd24684, 15'd24744, 15'd24576, 15'd24744, 4'd2},
    '{1'b0, 1'b1, 13'd0,    1'b0, 15'd0,     15'd0,     15'd24684, 15'd24744, 4'd9},
    '{1'b0, 1'b1, 13'd0,    1'b0, 15'd0,     15'd0,     15'd24744, 15'd24744, 4'd9},
    '{1'b1, 1'b0, 13'd4000, 1'b1, 15'd24744, 15'd28752, 15'd24744, 15'd28752, 4'd8},
    '{1'b1, 1'b0, 13'd3990, 1'b1, 15'd28752, 15'd32750, 15'd24744, 15'd32750, 4'd3},
    '{1'b0, 1'b1, 13'd0,    1'b0, 15'd0,     15'd0,     15'd28752, 15'd32750, 4'd9},
    '{1'b0, 1'b1, 13'd0,    1'b0, 15'd0,     15'd0,     15'd32750, 15'd32750, 4'd9},
    '{1'b1, 1'b0, 13'd20,   1'b1, 15'd32750, 15'd24586, 15'd32750, 15'd24586, 4'd6},
    '{1'b0, 1'b1, 13'd0,    1'b0, 15'd0,     15'd0,     15'd24586, 15'd24586, 4'd9},
    '{1'b1, 1'b0, 13'd4000, 1'b1, 15'd24586, 15'd28594, 15'd24586, 15'd28594, 4'd5},
    '{1'b1, 1'b0, 13'd4158, 1'b1, 15'd28594, 15'd32760, 15'd24586, 15'd32760, 4'd3},
    '{1'b0, 1'b1, 13'd0,    1'b0, 15'd0,     15'd0,     15'd28594, 15'd32760, 4'd9},
    '{1'b0, 1'b1, 13'd0,    1'b0, 15'd0,     15'd0,     15'd32760, 15'd32760, 4'd9},
    '{1'b1, 1'b0, 13'd10,   1'b1, 15'd24576, 15'd24594, 15'd24576, 15'd24594, 4'd7},
    '{1'b1, 1'b0, 13'd8160, 1'b0, 15'd0,     15'd0,     15'd24576, 15'd24594, 4'd4},
    '{1'b1, 1'b0, 13'd8158, 1'b1, 15'd24594, 15'd32760, 15'd24576, 15'd32760, 4'd3},
    '{1'b1, 1'b0, 13'd0,    1'b0, 15'd0,     15'd0,     15'd24576, 15'd32760, 4'd4},
    '{1'b0, 1'b1, 13'd0,    1'b0, 15'd0,     15'd0,     15'd24594, 15'd32760, 4'd9},
    '{1'b0, 1'b1, 13'd0,    1'b0, 15'd0,     15'd0,     15'd32760, 15'd32760, 4'd9},
    '{1'b0, 1'b1, 13'd0,    1'b0, 15'd0,     15'd0,     15'd32760, 15'd32760, 4'd9},
    '{1'b1, 1'b0, 13'd10,   1'b1, 15'd24576, 15'd24594, 15'd24576, 15'd24594, 4'd8},
    '{1'b1, 1'b1, 13'd4,    1'b1, 15'd24594, 15'd24606, 15'd24594, 15'd24606, 4'd10},
    '{1'b1, 1'b0, 13'd8146, 1'b1, 15'd24606, 15'd32760, 15'd24594, 15'd32760, 4'd5},
    '{1'b0, 1'b1, 13'd0,    1'b0, 15'd0,     15'd0,     15'd24606, 15'd32760, 4'd9},
    '{1'b1, 1'b1, 13'd10,   1'b1, 15'd24576, 15'd24594, 15'd24576, 15'd24594, 4'd10},
    '{1'b0, 1'b1, 13'd0,    1'b0, 15'd0,     15'd0,     15'd24594, 15'd24594, 4'd9}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [LW-1:0] req_len = '0;
  logic          cmpl_valid = 1'b0;
  logic          rsp_valid, rsp_accept;
  logic [AW-1:0] rsp_start, rsp_next, ring_head, ring_tail;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tx_ring_alloc u_tx_ring_alloc (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_len(req_len),
    .cmpl_valid(cmpl_valid), .rsp_valid(rsp_valid), .rsp_accept(rsp_accept),
    .rsp_start(rsp_start), .rsp_next(rsp_next),
    .ring_head(ring_head), .ring_tail(ring_tail)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic rq, input logic cp, input int len);
    req_valid  = rq;
    cmpl_valid = cp;
    req_len    = LW'(len);
    @(posedge clk);
    #1;
    req_valid  = 1'b0;
    cmpl_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    do_reset();
    // R1: reset state
    chk("R1 head after reset", int'(ring_head), 24576);
    chk("R1 tail after reset", int'(ring_tail), 24576);
    chk("R1 rsp_valid after reset", int'(rsp_valid), 0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].rq, VEC[i].cp, int'(VEC[i].len));
      if (VEC[i].rq) begin
        chk($sformatf("R11 valid vec%0d", i), int'(rsp_valid), 1);
        chk($sformatf("R%0d accept vec%0d", VEC[i].rid, i), int'(rsp_accept), int'(VEC[i].acc));
        if (VEC[i].acc) begin
          chk($sformatf("R%0d start vec%0d", VEC[i].rid, i), int'(rsp_start), int'(VEC[i].st));
          chk($sformatf("R%0d next vec%0d", VEC[i].rid, i), int'(rsp_next), int'(VEC[i].nx));
        end
      end else begin
        chk($sformatf("R11 quiet vec%0d", i), int'(rsp_valid), 0);
      end
      chk($sformatf("R%0d head vec%0d", VEC[i].rid, i), int'(ring_head), int'(VEC[i].hd));
      chk($sformatf("R%0d tail vec%0d", VEC[i].rid, i), int'(ring_tail), int'(VEC[i].tl));
    end

    // R11: response lasts one cycle only
    step(1'b1, 1'b0, 0);
    chk("R11 pulse high", int'(rsp_valid), 1);
    chk("R11 tail equals next", int'(ring_tail), int'(rsp_next));
    step(1'b0, 1'b0, 0);
    chk("R11 pulse low", int'(rsp_valid), 0);
    step(1'b0, 1'b1, 0);
    chk("R9 drain head", int'(ring_head), int'(ring_tail));

    // R12: outstanding frame limit (head=tail=24602 here)
    for (int k = 0; k < 16; k++) begin
      step(1'b1, 1'b0, 0);
      chk($sformatf("R12 accept %0d", k), int'(rsp_accept), 1);
      chk($sformatf("R12 start %0d", k), int'(rsp_start), 24602 + 8 * k);
    end
    step(1'b1, 1'b0, 0);
    chk("R12 reject when full", int'(rsp_accept), 0);
    chk("R4 tail kept when full", int'(ring_tail), 24602 + 128);
    for (int k = 0; k < 16; k++) step(1'b0, 1'b1, 0);
    chk("R9 head after drain", int'(ring_head), 24602 + 128);

    // R1: reset in mid-run
    step(1'b1, 1'b0, 300);
    do_reset();
    chk("R1 head after second reset", int'(ring_head), 24576);
    chk("R1 tail after second reset", int'(ring_tail), 24576);
    chk("R1 rsp_valid after second reset", int'(rsp_valid), 0);

    summary();
  end

endmodule